// File: doc/BRIEF.md
# Reset Output Sequencer with Power-Up Configuration Capture

This block turns an external active-low reset request into two reset outputs: one drives devices outside the chip, the other drives internal logic. A reset request pulls both outputs low at once, without waiting for a clock edge. Release is gated by the clock generator's lock indication, not by a fixed delay. Both outputs stay low while lock is absent. They go high on the same clock edge once lock is present again.

While the reset request is low, the block also samples the shared data pins on every clock and holds the last value in a configuration register. When the negated request has passed through the synchroniser, the register freezes and a valid flag goes high. This block does not decode the meaning of the configuration bits.

If lock drops later while the request stays negated, both reset outputs go low again until lock returns. The captured configuration is not touched in that case. All pins are plain level signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `rcl_reset_cfg`

## Requirements
- R1: While `rst_in_n` is 0, `rst_out_n`, `int_rst_n` and `cfg_valid` are 0, and this takes effect without waiting for a clock edge.
- R2: A rising `rst_in_n` passes through SYNC_STAGES (default 2) flip-flops. The block sees the request as negated from the SYNC_STAGES-th rising edge after the rise.
- R3: `pll_lock` passes through LOCK_STAGES (default 2) flip-flops, and these are cleared while `rst_in_n` is 0. With the defaults, if `pll_lock` is 1 from the d-th edge after `rst_in_n` rises (d=0 meaning from the rise itself), `rst_out_n` first reads 1 after edge max(4, d+3). It never rises while the synchronised lock is 0.
- R4: `cfg_value` holds the `cfg_pins` value sampled at edge 2 after the rise of `rst_in_n`. Later changes on `cfg_pins` have no effect on `cfg_value`.
- R5: `cfg_value` is captured when the second synchroniser stage still reads 0, which is edge 2 after the rise of `rst_in_n`. `cfg_valid` goes to 1 one edge later, at edge 3, and holds until `rst_in_n` goes low again.
- R6: `int_rst_n` and `rst_out_n` are equal after every clock edge, so both release on the same edge.
- R7: If `pll_lock` falls while the block is running, both reset outputs read 0 after the 3rd edge that follows. They read 1 again 3 edges after `pll_lock` returns. `cfg_value` and `cfg_valid` do not change during this.
- R8: While `rst_in_n` is 0, every clock edge loads `cfg_pins` into `cfg_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the synchronisers and all registers |
| rst_in_n | input | 1 | External reset request, active low, may change at any time |
| pll_lock | input | 1 | Lock indication from the clock generator, 1 when locked |
| cfg_pins | input | CFG_W | Shared data pins that are sampled during reset |
| rst_out_n | output | 1 | Reset driven to external devices, active low |
| int_rst_n | output | 1 | Reset for internal logic, active low |
| cfg_value | output | CFG_W | Configuration value captured during reset |
| cfg_valid | output | 1 | 1 once `cfg_value` has frozen |

## Verification
The bench builds the block with its default parameters: CFG_W=8, SYNC_STAGES=2 and LOCK_STAGES=2. With these values the release edge can be written as max(4, d+3) for a lock delay of d edges. A single table of release scenarios can therefore check the exact release cycle, both when reset synchronisation is the limit and when lock is the limit. The narrow configuration width allows patterns of all zeros, all ones and alternating bits in a short run.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
  localparam int DEF_CFG_W       = 8;
  localparam int DEF_SYNC_STAGES = 2;
  localparam int DEF_LOCK_STAGES = 2;

  typedef enum logic [1:0] {
    PH_HELD    = 2'd0,
    PH_CAPTURE = 2'd1,
    PH_RUN     = 2'd2,
    PH_RELOCK  = 2'd3
  } rcl_phase_e;
endpackage

// File: rtl/rcl_sync_chain.sv
module rcl_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_in,
  output logic q_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stage_q[0] <= 1'b0;
          else         stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stage_q[g] <= 1'b0;
          else         stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[LAST];
endmodule

// File: rtl/rcl_cfg_latch.sv
module rcl_cfg_latch #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             seen_released,
  input  logic [CFG_W-1:0] pins,
  output logic [CFG_W-1:0] cfg_q,
  output logic             valid_q
);
  // Sampling needs the clock to run while in reset, so there is no reset here.
  always_ff @(posedge clk) begin
    if (!seen_released) cfg_q <= pins;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) valid_q <= 1'b0;
    else         valid_q <= seen_released;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!arst_n)
    (valid_q && $past(valid_q)) |-> $stable(cfg_q)); // R4
  AST_VALID_AFTER_SEEN: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(valid_q) |-> seen_released); // R5
endmodule

// File: rtl/rcl_release.sv
module rcl_release
  import rcl_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic seen_released,
  input  logic lock_s,
  input  logic cfg_valid,
  output logic ext_rst_n,
  output logic core_rst_n
);
  rcl_phase_e phase_q, phase_d;
  logic       go;

  assign go = cfg_valid & lock_s;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_HELD:    if (seen_released) phase_d = PH_CAPTURE;
      PH_CAPTURE: if (go)            phase_d = PH_RUN;
      PH_RUN:     if (!lock_s)       phase_d = PH_RELOCK;
      PH_RELOCK:  if (go)            phase_d = PH_RUN;
      default:                       phase_d = PH_HELD;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) phase_q <= PH_HELD;
    else         phase_q <= phase_d;
  end

  // Two separate flops: one for the pin, one for the internal fan-out.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ext_rst_n <= 1'b0;
    else         ext_rst_n <= go;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) core_rst_n <= 1'b0;
    else         core_rst_n <= (phase_d == PH_RUN);
  end

  AST_NO_RELEASE_UNLOCKED: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(ext_rst_n) |-> $past(lock_s)); // R3
  AST_LOCK_LOSS_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    $past(!lock_s) |-> !ext_rst_n); // R7
endmodule

// File: rtl/rcl_reset_cfg.sv
module rcl_reset_cfg
  import rcl_pkg::*;
#(
  parameter int CFG_W       = DEF_CFG_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int LOCK_STAGES = DEF_LOCK_STAGES
) (
  input  logic             clk,
  input  logic             rst_in_n,
  input  logic             pll_lock,
  input  logic [CFG_W-1:0] cfg_pins,
  output logic             rst_out_n,
  output logic             int_rst_n,
  output logic [CFG_W-1:0] cfg_value,
  output logic             cfg_valid
);
  logic seen_released;
  logic lock_s;

  rcl_sync_chain #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_in_n),
    .d_in   (1'b1),
    .q_out  (seen_released)
  );

  rcl_sync_chain #(.STAGES(LOCK_STAGES)) u_lock_sync (
    .clk    (clk),
    .arst_n (rst_in_n),
    .d_in   (pll_lock),
    .q_out  (lock_s)
  );

  rcl_cfg_latch #(.CFG_W(CFG_W)) u_cfg (
    .clk           (clk),
    .arst_n        (rst_in_n),
    .seen_released (seen_released),
    .pins          (cfg_pins),
    .cfg_q         (cfg_value),
    .valid_q       (cfg_valid)
  );

  rcl_release u_rel (
    .clk           (clk),
    .arst_n        (rst_in_n),
    .seen_released (seen_released),
    .lock_s        (lock_s),
    .cfg_valid     (cfg_valid),
    .ext_rst_n     (rst_out_n),
    .core_rst_n    (int_rst_n)
  );

  AST_OUT_LOW_IN_RESET: assert property (@(posedge clk)
    !rst_in_n |-> (!rst_out_n && !int_rst_n && !cfg_valid)); // R1
  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_in_n)
    rst_out_n == int_rst_n); // R6
  AST_OUT_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_in_n)
    rst_out_n |-> cfg_valid); // R5
endmodule

// File: tb/tb_rcl_reset_cfg.sv
`timescale 1ns/1ps
module tb_rcl_reset_cfg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_in_n;
  logic         pll_lock;
  logic [W-1:0] cfg_pins;
  logic         rst_out_n;
  logic         int_rst_n;
  logic [W-1:0] cfg_value;
  logic         cfg_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rcl_reset_cfg dut (
    .clk(clk), .rst_in_n(rst_in_n), .pll_lock(pll_lock), .cfg_pins(cfg_pins),
    .rst_out_n(rst_out_n), .int_rst_n(int_rst_n),
    .cfg_value(cfg_value), .cfg_valid(cfg_valid)
  );

  // Each entry: pins pattern, lock delay d, expected release edge.
  localparam logic [23:0] VEC [6] = '{
    {8'hA5, 8'd0, 8'd4},
    {8'h3C, 8'd1, 8'd4},
    {8'h0F, 8'd2, 8'd5},
    {8'hF0, 8'd5, 8'd8},
    {8'h00, 8'd9, 8'd12},
    {8'hFF, 8'd3, 8'd6}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_in_n = 1'b0;
    pll_lock = 1'b0;
    cfg_pins = 8'h11;
    @(negedge clk);
    cyc();
    cyc();
    check(!rst_out_n && !int_rst_n && !cfg_valid, "R1", {rst_out_n, int_rst_n, cfg_valid}, 0);

    // R8: the register follows the pins while reset is held
    cfg_pins = 8'h5A;
    cyc();
    check(cfg_value == 8'h5A, "R8", cfg_value, 8'h5A);
    cfg_pins = 8'hC3;
    cyc();
    check(cfg_value == 8'hC3, "R8", cfg_value, 8'hC3);

    foreach (VEC[i]) begin
      logic [7:0] pat, dly, expe;
      int first;
      int mism;
      {pat, dly, expe} = VEC[i];
      rst_in_n = 1'b0;
      pll_lock = 1'b0;
      cfg_pins = pat;
      cyc();
      cyc();
      check(!rst_out_n && !cfg_valid, "R1", {rst_out_n, cfg_valid}, 0);
      rst_in_n = 1'b1;
      if (dly == 0) pll_lock = 1'b1;
      first = 0;
      mism = 0;
      for (int n = 1; n <= 16; n++) begin
        cyc();
        if (rst_out_n != int_rst_n) mism++;
        if (rst_out_n && first == 0) first = n;
        if (n == 2) check(!cfg_valid, "R5", cfg_valid, 0);
        if (n == 3) check(cfg_valid, "R5", cfg_valid, 1);
        if (n == 2) cfg_pins = ~pat;
        if (n == int'(dly)) pll_lock = 1'b1;
      end
      check(first == int'(expe), "R3", first, expe);
      check(mism == 0, "R6", mism, 0);
      check(cfg_value == pat, "R4", cfg_value, pat);
    end

    // R7: lock loss while running
    cfg_pins = 8'h99;
    pll_lock = 1'b0;
    cyc();
    cyc();
    check(rst_out_n, "R7", rst_out_n, 1);
    cyc();
    check(!rst_out_n && !int_rst_n, "R7", {rst_out_n, int_rst_n}, 0);
    check(cfg_value == 8'hFF && cfg_valid, "R7", cfg_value, 8'hFF);
    pll_lock = 1'b1;
    cyc();
    cyc();
    check(!rst_out_n, "R7", rst_out_n, 0);
    cyc();
    check(rst_out_n && int_rst_n, "R7", {rst_out_n, int_rst_n}, 3);

    // R1: assertion between edges takes effect at once
    #1;
    rst_in_n = 1'b0;
    #0.5;
    check(!rst_out_n && !int_rst_n && !cfg_valid, "R1", {rst_out_n, int_rst_n, cfg_valid}, 0);

    // R2: release is seen at edge 2 (cfg last sampled there)
    @(negedge clk);
    cfg_pins = 8'h21;
    rst_in_n = 1'b1;
    cyc();
    cfg_pins = 8'h42;
    cyc();
    cfg_pins = 8'h84;
    cyc();
    check(cfg_value == 8'h42, "R2", cfg_value, 8'h42);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule